// File: doc/BRIEF.md
# Lockable bark-bite watchdog timer

This block is a two-stage watchdog. Firmware sets a lower "bark" limit and an upper "bite" limit, then enables counting. While enabled, each one-cycle pulse on the slow tick input advances a count. Once the count has reached the bark limit, a level interrupt rises. Once it has reached the bite limit, a single-cycle reset-request pulse goes out. Software services the dog by rewriting the count. It acknowledges the interrupt by writing one to the status bit. If the count is still at or past the bark limit at that point, the interrupt comes back on the next tick.

A one-way lock register freezes the control word and both limits until the next reset. The count itself stays writable after locking, so a locked dog can still be fed. Access is through a plain word-addressed port: 4-bit address, write strobe, 32-bit write data, and read data that follows the address combinationally. Word addresses 0 to 3, 10 and 11 are placeholders for functions outside this block.

Top module: `wdog_lock_timer`

## Requirements
- R1: After reset the lock register (address 4) reads 1 and every other register reads 0; `bark_irq_o` and `bite_o` are low.
- R2: While the lock register reads 1, a write to it stores only write-data bit 0. Once it reads 0, writes to it are ignored until reset.
- R3: Writes to control (address 5), bark limit (address 6) and bite limit (address 7) take effect only while unlocked. Control keeps write-data bits 1:0 (bit 0 enable, bit 1 pause-in-sleep); the limits keep all 32 bits.
- R4: The count register (address 8) can be written whether or not the block is locked. The written value replaces the count on the next cycle. A write in the same cycle as a tick takes priority over the tick.
- R5: While enabled, each `tick_i` pulse adds one to the count. When control bit 1 is set and `sleep_i` is high, ticks leave the count unchanged.
- R6: On a counting tick at which the count is greater than or equal to the bark limit, status bit 1 (address 9) is set and `bark_irq_o` goes high from the next cycle. Both stay set until cleared.
- R7: Writing 1 to bit 1 of address 9 clears the bark status and `bark_irq_o` on the next cycle. If the count is still at or above the bark limit, the next counting tick sets them again.
- R8: `bite_o` pulses high for exactly one cycle, in the cycle after a counting tick at which the count is greater than or equal to the bite limit. It does not pulse again until the count is written with a value below the bite limit.
- R9: With control bit 0 clear, ticks neither change the count, nor set the bark status, nor pulse `bite_o`.
- R10: Addresses 0 to 3, 10, 11 and 12 to 15 always read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle tick from the slow always-on time base |
| sleep_i | input | 1 | System sleep indication |
| addr_i | input | 4 | Register word address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| bark_irq_o | output | 1 | Bark interrupt, level |
| bite_o | output | 1 | Reset request, one-cycle pulse |

## Verification
Some properties are checked on every cycle. The lock never reopens, and the locked configuration never changes. A count write lands on the next cycle. A paused count holds. A bite pulse never lasts two cycles. A disabled block starts no new bark or bite. An acknowledge with no tick drops the interrupt.

Other behaviour depends on exact arithmetic against the limits, so only the bench's directed scenarios can show it. That covers the tick at which the bark and bite limits are first met, the bark re-firing after an acknowledge, the bite re-arming only after a write below its limit, and the values of the ignored placeholder registers.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    RA_ALERT   = 4'd0,
    RA_WK_CTRL = 4'd1,
    RA_WK_THR  = 4'd2,
    RA_WK_CNT  = 4'd3,
    RA_LOCK    = 4'd4,
    RA_CTRL    = 4'd5,
    RA_BARK    = 4'd6,
    RA_BITE    = 4'd7,
    RA_COUNT   = 4'd8,
    RA_ISTATE  = 4'd9,
    RA_ITEST   = 4'd10,
    RA_WK_WHY  = 4'd11
  } reg_addr_e;

  typedef struct packed {
    logic pause;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/wdt_cfg.sv
module wdt_cfg
  import wdt_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_lock_i,
  input  logic          wr_ctrl_i,
  input  logic          wr_bark_i,
  input  logic          wr_bite_i,
  input  logic [DW-1:0] wdata_i,
  output logic          unlocked_o,
  output ctrl_t         ctrl_o,
  output logic [DW-1:0] bark_th_o,
  output logic [DW-1:0] bite_th_o
);
  logic unlocked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unlocked_q <= 1'b1;
      ctrl_o     <= '0;
      bark_th_o  <= '0;
      bite_th_o  <= '0;
    end else if (unlocked_q) begin
      if (wr_lock_i) unlocked_q <= wdata_i[0];
      if (wr_ctrl_i) ctrl_o     <= ctrl_t'(wdata_i[1:0]);
      if (wr_bark_i) bark_th_o  <= wdata_i;
      if (wr_bite_i) bite_th_o  <= wdata_i;
    end
  end

  assign unlocked_o = unlocked_q;
endmodule

// File: rtl/wdt_core.sv
module wdt_core
  import wdt_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          sleep_i,
  input  ctrl_t         ctrl_i,
  input  logic [DW-1:0] bark_th_i,
  input  logic [DW-1:0] bite_th_i,
  input  logic          cnt_wr_i,
  input  logic [DW-1:0] cnt_wdata_i,
  input  logic          irq_clr_i,
  output logic [DW-1:0] cnt_o,
  output logic          bark_o,
  output logic          bite_o
);
  logic tick_act, bark_hit, bite_hit, bite_done_q;

  // a count write owns the cycle; no compare against the stale value
  assign tick_act = ctrl_i.en & tick_i & ~(ctrl_i.pause & sleep_i) & ~cnt_wr_i;
  assign bark_hit = tick_act & (cnt_o >= bark_th_i);
  assign bite_hit = tick_act & (cnt_o >= bite_th_i) & ~bite_done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o       <= '0;
      bark_o      <= 1'b0;
      bite_o      <= 1'b0;
      bite_done_q <= 1'b0;
    end else begin
      if (cnt_wr_i)      cnt_o <= cnt_wdata_i;
      else if (tick_act) cnt_o <= cnt_o + DW'(1);
      bark_o <= bark_hit | (bark_o & ~irq_clr_i);
      bite_o <= bite_hit;
      if (cnt_wr_i && (cnt_wdata_i < bite_th_i)) bite_done_q <= 1'b0;
      else if (bite_hit)                         bite_done_q <= 1'b1;
    end
  end
endmodule

// File: rtl/wdog_lock_timer.sv
module wdog_lock_timer
  import wdt_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              sleep_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic              bark_irq_o,
  output logic              bite_o
);
  localparam int unsigned BARK_BIT = 1;

  logic          unlocked;
  ctrl_t         ctrl;
  logic [DW-1:0] bark_th, bite_th, cnt;
  logic          wr_lock, wr_ctrl, wr_bark, wr_bite, wr_cnt, wr_ist;

  assign wr_lock = we_i && (addr_i == RA_LOCK);
  assign wr_ctrl = we_i && (addr_i == RA_CTRL);
  assign wr_bark = we_i && (addr_i == RA_BARK);
  assign wr_bite = we_i && (addr_i == RA_BITE);
  assign wr_cnt  = we_i && (addr_i == RA_COUNT);
  assign wr_ist  = we_i && (addr_i == RA_ISTATE);

  wdt_cfg #(.DW(DW)) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_lock_i  (wr_lock),
    .wr_ctrl_i  (wr_ctrl),
    .wr_bark_i  (wr_bark),
    .wr_bite_i  (wr_bite),
    .wdata_i    (wdata_i),
    .unlocked_o (unlocked),
    .ctrl_o     (ctrl),
    .bark_th_o  (bark_th),
    .bite_th_o  (bite_th)
  );

  wdt_core #(.DW(DW)) u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .sleep_i     (sleep_i),
    .ctrl_i      (ctrl),
    .bark_th_i   (bark_th),
    .bite_th_i   (bite_th),
    .cnt_wr_i    (wr_cnt),
    .cnt_wdata_i (wdata_i),
    .irq_clr_i   (wr_ist & wdata_i[BARK_BIT]),
    .cnt_o       (cnt),
    .bark_o      (bark_irq_o),
    .bite_o      (bite_o)
  );

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      RA_LOCK:   rdata_o = DW'(unlocked);
      RA_CTRL:   rdata_o = DW'(ctrl);
      RA_BARK:   rdata_o = bark_th;
      RA_BITE:   rdata_o = bite_th;
      RA_COUNT:  rdata_o = cnt;
      RA_ISTATE: rdata_o = DW'(bark_irq_o) << BARK_BIT;
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker
  import wdt_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              sleep_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic [DW-1:0]     wdata_i,
  input logic              unlocked_i,
  input logic [1:0]        ctrl_i,
  input logic [DW-1:0]     bark_th_i,
  input logic [DW-1:0]     bite_th_i,
  input logic [DW-1:0]     cnt_i,
  input logic              bark_irq_i,
  input logic              bite_i
);
  logic cnt_wr;
  assign cnt_wr = we_i && (addr_i == RA_COUNT);

  AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !unlocked_i |=> !unlocked_i); // R2
  AST_CFG_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !unlocked_i |=> ($stable(ctrl_i) && $stable(bark_th_i) && $stable(bite_th_i))); // R3
  AST_COUNT_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_wr |=> (cnt_i == $past(wdata_i))); // R4
  AST_SLEEP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i == 2'b11 && sleep_i && !cnt_wr) |=> $stable(cnt_i)); // R5
  AST_ACK_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == RA_ISTATE && wdata_i[1] && !tick_i) |=> !bark_irq_i); // R7
  AST_BITE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bite_i |=> !bite_i); // R8
  AST_OFF_NO_BITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_i[0] |=> !bite_i); // R9
  AST_OFF_NO_BARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_i[0] && !bark_irq_i) |=> !bark_irq_i); // R9
endmodule

bind wdog_lock_timer wdt_checker #(.DW(DW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .sleep_i    (sleep_i),
  .addr_i     (addr_i),
  .we_i       (we_i),
  .wdata_i    (wdata_i),
  .unlocked_i (unlocked),
  .ctrl_i     (ctrl),
  .bark_th_i  (bark_th),
  .bite_th_i  (bite_th),
  .cnt_i      (cnt),
  .bark_irq_i (bark_irq_o),
  .bite_i     (bite_o)
);

// File: tb/sim_wdog_lock_timer.sv
`timescale 1ns/1ps
module sim_wdog_lock_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, sleep = 1'b0, we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, bite;
  int          total = 0, bad = 0, bites = 0;

  always #2.5 clk = ~clk;

  wdog_lock_timer u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .sleep_i(sleep),
    .addr_i(addr), .we_i(we), .wdata_i(wdata), .rdata_o(rdata),
    .bark_irq_o(irq), .bite_o(bite)
  );

  always @(negedge clk) if (bite) bites++;

  typedef struct packed {
    logic [3:0]  a;
    logic [31:0] d;
    logic [31:0] e;
  } vec_t;

  // write d to a, then read a back expecting e (R2 R3 R4 R10)
  localparam vec_t VECS [15] = '{
    '{4'd5,  32'hFFFF_FFFF, 32'h3},
    '{4'd5,  32'h0,         32'h0},
    '{4'd6,  32'h1234_5678, 32'h1234_5678},
    '{4'd7,  32'hCAFE_0001, 32'hCAFE_0001},
    '{4'd8,  32'h55,        32'h55},
    '{4'd8,  32'h0,         32'h0},
    '{4'd4,  32'hFFFF_FFFF, 32'h1},
    '{4'd0,  32'hFFFF_FFFF, 32'h0},
    '{4'd1,  32'hFFFF,      32'h0},
    '{4'd2,  32'h1234,      32'h0},
    '{4'd3,  32'h77,        32'h0},
    '{4'd10, 32'h3,         32'h0},
    '{4'd11, 32'h1,         32'h0},
    '{4'd13, 32'hABCD,      32'h0},
    '{4'd9,  32'h2,         32'h0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; we = 1'b0; #1; d = rdata;
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  initial begin
    #500000;
    bad++;
    $display("FAIL watchdog expired act=hang exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(4'd4, v); chk("R1 lock", v, 32'h1);
    rd(4'd5, v); chk("R1 ctrl", v, 32'h0);
    rd(4'd8, v); chk("R1 count", v, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 bite", {31'b0, bite}, 32'h0);

    for (int i = 0; i < 15; i++) begin
      wr(VECS[i].a, VECS[i].d);
      rd(VECS[i].a, v);
      chk($sformatf("R2/R3/R4/R10 vec %0d", i), v, VECS[i].e);
    end
    rd(4'd15, v); chk("R10 addr15", v, 32'h0);

    // R6 bark threshold
    wr(4'd6, 32'd3); wr(4'd7, 32'd6); wr(4'd8, 32'd0); wr(4'd5, 32'd1);
    pulse(3);
    chk("R6 below bark", {31'b0, irq}, 32'h0);
    pulse(1);
    chk("R6 bark raised", {31'b0, irq}, 32'h1);
    rd(4'd9, v); chk("R6 status", v, 32'h2);
    rd(4'd8, v); chk("R5 count", v, 32'd4);

    // R8 bite pulse
    pulse(2);
    chk("R8 no bite yet", bites, 0);
    pulse(1);
    @(negedge clk);
    chk("R8 one pulse", bites, 1);
    pulse(2);
    chk("R8 no repeat", bites, 1);

    // R7 clear and re-fire
    wr(4'd9, 32'h2);
    chk("R7 cleared", {31'b0, irq}, 32'h0);
    rd(4'd9, v); chk("R7 status cleared", v, 32'h0);
    pulse(1);
    chk("R7 re-fire", {31'b0, irq}, 32'h1);

    // R8 re-arm after write below limit
    wr(4'd8, 32'd0); wr(4'd9, 32'h2);
    pulse(2);
    chk("R6 fresh count quiet", {31'b0, irq}, 32'h0);
    wr(4'd8, 32'd6);
    pulse(1);
    @(negedge clk);
    chk("R8 re-armed", bites, 2);

    // R5 pause in sleep
    wr(4'd5, 32'd3); sleep = 1'b1; wr(4'd8, 32'd10);
    pulse(3);
    rd(4'd8, v); chk("R5 paused", v, 32'd10);
    sleep = 1'b0; pulse(1);
    rd(4'd8, v); chk("R5 resumed", v, 32'd11);
    wr(4'd5, 32'd1); sleep = 1'b1; pulse(1);
    rd(4'd8, v); chk("R5 sleep no pause", v, 32'd12);
    sleep = 1'b0;

    // R9 disabled
    wr(4'd5, 32'd0); wr(4'd9, 32'h2); wr(4'd8, 32'd0); wr(4'd8, 32'd100);
    pulse(3);
    chk("R9 no bark", {31'b0, irq}, 32'h0);
    chk("R9 no bite", bites, 2);
    rd(4'd8, v); chk("R9 count held", v, 32'd100);
    wr(4'd5, 32'd1); pulse(1);
    @(negedge clk);
    chk("R9 re-enabled bite", bites, 3);
    chk("R9 re-enabled bark", {31'b0, irq}, 32'h1);

    // R2 R3 R4 lock
    wr(4'd5, 32'd0); wr(4'd9, 32'h2);
    wr(4'd4, 32'd0);
    rd(4'd4, v); chk("R2 locked", v, 32'h0);
    wr(4'd5, 32'd1); rd(4'd5, v); chk("R3 ctrl frozen", v, 32'h0);
    wr(4'd6, 32'd50); rd(4'd6, v); chk("R3 bark frozen", v, 32'd3);
    wr(4'd7, 32'd50); rd(4'd7, v); chk("R3 bite frozen", v, 32'd6);
    wr(4'd4, 32'd1); rd(4'd4, v); chk("R2 stays locked", v, 32'h0);
    wr(4'd8, 32'd7); rd(4'd8, v); chk("R4 count writable", v, 32'd7);

    // R1 reset again
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd(4'd4, v); chk("R1 lock reopened", v, 32'h1);
    rd(4'd6, v); chk("R1 bark zero", v, 32'h0);
    rd(4'd8, v); chk("R1 count zero", v, 32'h0);
    chk("R1 irq low", {31'b0, irq}, 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule